// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a 64-bit watchdog counter behind a small register bus. A host writes registers through an address, a write-data word and a write strobe. Read data comes back registered, one cycle after the address is presented. The count advances on an external tick input. When the count reaches a programmed 64-bit period, the block marks a timeout and drives a reset request output for a fixed number of clock cycles.

Software arms the watchdog with two 16-bit keys written to the watchdog control word in a fixed order. The watchdog moves from off to a waiting (pre-armed) state and then to running. While it runs, software keeps it alive by writing the same two keys again, in the same order. Once it runs, every configuration write is ignored until the block's own reset. This keeps a runaway program from switching the watchdog off.

Top module: `kwdog_top`

## Requirements
- R1: After reset, all seven registers read zero and `wd_rst_o` is low.
- R2: The registers sit at these byte addresses: counter low 0x10, counter high 0x14, period low 0x18, period high 0x1C, timer control 0x20, global control 0x24, watchdog control 0x28. Timer control holds the enable mode in bits 7:6. Global control holds the low-half release in bit 0, the high-half release in bit 1 and the mode in bits 3:2. Writes read back one cycle after the address is presented, and an unmapped address reads zero.
- R3: A counter half whose release bit in global control is 0 is held at zero, and writes to it are lost.
- R4: Watchdog control holds the key in bits 31:16, the enable in bit 14 and the timeout flag in bit 15. Enable reads 1 whenever the watchdog is pre-armed or running. Writing key 0xA5C6 with bit 14 set while off moves the watchdog to pre-armed, but only when the global mode field is 2. Writing key 0xDA7E with bit 14 set while pre-armed moves it to running. Arming does not change the count.
- R5: While pre-armed, any watchdog-control write other than 0xDA7E or 0xA5C6 with bit 14 set returns the watchdog to off. Writing 0xDA7E while off does nothing.
- R6: While running, each tick adds one to the 64-bit count, with a carry from the low half into the high half. A tick counts only when both release bits are 1 and the enable mode is nonzero.
- R7: While running, once the count is greater than or equal to {period high, period low}, the next clock edge does three things: it sets the flag, clears the count, and raises `wd_rst_o` for exactly RST_LEN cycles.
- R8: While running, writing key 0xA5C6 and then key 0xDA7E clears the count. Bit 14 does not matter for these writes.
- R9: A watchdog-control write whose key is not the expected next one resets the keep-alive sequence without clearing the count. Key 0xA5C6 always counts as the first step.
- R10: While running, writes to the counters, the periods, timer control and global control are ignored. Clearing bit 14 does not stop the watchdog.
- R11: Writing 1 to bit 15 of watchdog control clears the flag. If a timeout happens in the same cycle, the flag stays set.
- R12: When the second keep-alive key lands in the same cycle as a period match, the keep-alive wins: there is no flag and no reset pulse, and the count clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-advance strobe |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | DW (32) | Registered read data |
| wd_rst_o | output | 1 | Timeout reset request, RST_LEN cycles wide |

## Verification
Two pairs of events can fall in the same cycle. In the first pair, the closing keep-alive key coincides with a period match. The bench steps the count to one below the period, sends a final tick, and writes 0xDA7E on the very next cycle. The expected result is no pulse, a clear flag and a zero count. In the second pair, a flag-clear write coincides with a timeout. The same tick-then-write pattern is used, and the flag must still read set afterwards.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
  typedef enum logic [1:0] {
    WD_OFF = 2'd0,
    WD_PRE = 2'd1,
    WD_RUN = 2'd2
  } wd_state_e;

  localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [15:0] KEY_SECOND = 16'hDA7E;
  localparam logic [1:0]  MODE_WDOG  = 2'd2;

  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PRD_LO = 8'h18;
  localparam logic [7:0] OFS_PRD_HI = 8'h1C;
  localparam logic [7:0] OFS_TCTL   = 8'h20;
  localparam logic [7:0] OFS_GCTL   = 8'h24;
  localparam logic [7:0] OFS_WCTL   = 8'h28;

  localparam int TMODE_LSB = 6;
  localparam int GMODE_LSB = 2;
  localparam int WEN_BIT   = 14;
  localparam int WFLAG_BIT = 15;
endpackage

// File: rtl/kwdog_keyseq.sv
module kwdog_keyseq
  import kwdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        key_wr,
  input  logic [15:0] key,
  input  logic        en_bit,
  input  logic        mode_ok,
  output logic        st_pre,
  output logic        st_run,
  output logic        svc_go
);
  wd_state_e state_q, state_d;
  logic      stage_q, stage_d;

  always_comb begin
    state_d = state_q;
    stage_d = stage_q;
    svc_go  = 1'b0;
    if (key_wr) begin
      case (state_q)
        WD_OFF: begin
          if (key == KEY_FIRST && en_bit && mode_ok) state_d = WD_PRE;
        end
        WD_PRE: begin
          if (key == KEY_SECOND && en_bit)     state_d = WD_RUN;
          else if (key == KEY_FIRST && en_bit) state_d = WD_PRE;
          else                                 state_d = WD_OFF;
        end
        WD_RUN: begin
          if (key == KEY_FIRST) begin
            stage_d = 1'b1;
          end else if (key == KEY_SECOND && stage_q) begin
            svc_go  = 1'b1;
            stage_d = 1'b0;
          end else begin
            stage_d = 1'b0;
          end
        end
        default: state_d = WD_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WD_OFF;
      stage_q <= 1'b0;
    end else begin
      state_q <= state_d;
      stage_q <= stage_d;
    end
  end

  assign st_pre = (state_q == WD_PRE);
  assign st_run = (state_q == WD_RUN);
endmodule

// File: rtl/kwdog_count.sv
module kwdog_count #(
  parameter int HALF_W = 32,
  localparam int CW = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        run_half,
  input  logic              clr,
  input  logic [1:0]        wr_half,
  input  logic [HALF_W-1:0] wdata,
  input  logic              inc,
  output logic [CW-1:0]     cnt
);
  logic [1:0][HALF_W-1:0] half_q;
  logic [1:0]             cin;

  assign cin[0] = inc;
  assign cin[1] = inc && (&half_q[0]);

  for (genvar g = 0; g < 2; g++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst || !run_half[g])  half_q[g] <= '0;
      else if (clr)             half_q[g] <= '0;
      else if (wr_half[g])      half_q[g] <= wdata;
      else if (cin[g])          half_q[g] <= half_q[g] + 1'b1;
    end
  end

  assign cnt = {half_q[1], half_q[0]};
endmodule

// File: rtl/kwdog_pulse.sv
module kwdog_pulse #(
  parameter int LEN = 8,
  localparam int LW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_o
);
  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pulse_o <= 1'b0;
    end else if (fire) begin
      left_q  <= LW'(LEN - 1);
      pulse_o <= 1'b1;
    end else if (left_q != '0) begin
      left_q  <= left_q - 1'b1;
    end else begin
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
  import kwdog_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int RST_LEN = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  output logic [DW-1:0] bus_rdata,
  output logic          wd_rst_o
);
  localparam int CW      = 2 * DW;
  localparam int KEY_LSB = DW - 16;

  logic [CW-1:0] prd_q;
  logic [CW-1:0] cnt_w;
  logic [1:0]    tmode_q;
  logic [1:0]    grun_q;
  logic [1:0]    gmode_q;
  logic          flag_q;
  logic          st_pre, st_run, svc_go;
  logic          hit_clo, hit_chi, hit_plo, hit_phi, hit_tctl, hit_gctl, hit_wctl;
  logic          cfg_wr_ok, cnt_inc, tmo;
  logic [DW-1:0] rd_mux;

  assign hit_clo  = bus_wr && (bus_addr == AW'(OFS_CNT_LO));
  assign hit_chi  = bus_wr && (bus_addr == AW'(OFS_CNT_HI));
  assign hit_plo  = bus_wr && (bus_addr == AW'(OFS_PRD_LO));
  assign hit_phi  = bus_wr && (bus_addr == AW'(OFS_PRD_HI));
  assign hit_tctl = bus_wr && (bus_addr == AW'(OFS_TCTL));
  assign hit_gctl = bus_wr && (bus_addr == AW'(OFS_GCTL));
  assign hit_wctl = bus_wr && (bus_addr == AW'(OFS_WCTL));
  assign cfg_wr_ok = !st_run;

  kwdog_keyseq u_keys (
    .clk     (clk),
    .rst     (rst),
    .key_wr  (hit_wctl),
    .key     (bus_wdata[KEY_LSB +: 16]),
    .en_bit  (bus_wdata[WEN_BIT]),
    .mode_ok (gmode_q == MODE_WDOG),
    .st_pre  (st_pre),
    .st_run  (st_run),
    .svc_go  (svc_go)
  );

  assign cnt_inc = tick && st_run && (&grun_q) && (tmode_q != 2'd0);
  assign tmo     = st_run && (cnt_w >= prd_q) && !svc_go;

  kwdog_count #(.HALF_W(DW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run_half (grun_q),
    .clr      (svc_go || tmo),
    .wr_half  ({hit_chi && cfg_wr_ok, hit_clo && cfg_wr_ok}),
    .wdata    (bus_wdata),
    .inc      (cnt_inc),
    .cnt      (cnt_w)
  );

  kwdog_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .fire    (tmo),
    .pulse_o (wd_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_q   <= '0;
      tmode_q <= '0;
      grun_q  <= '0;
      gmode_q <= '0;
    end else if (cfg_wr_ok) begin
      if (hit_plo)  prd_q[DW-1:0]  <= bus_wdata;
      if (hit_phi)  prd_q[CW-1:DW] <= bus_wdata;
      if (hit_tctl) tmode_q        <= bus_wdata[TMODE_LSB +: 2];
      if (hit_gctl) begin
        grun_q  <= bus_wdata[1:0];
        gmode_q <= bus_wdata[GMODE_LSB +: 2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   flag_q <= 1'b0;
    else if (tmo)                              flag_q <= 1'b1;
    else if (hit_wctl && bus_wdata[WFLAG_BIT]) flag_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(OFS_CNT_LO): rd_mux = cnt_w[DW-1:0];
      AW'(OFS_CNT_HI): rd_mux = cnt_w[CW-1:DW];
      AW'(OFS_PRD_LO): rd_mux = prd_q[DW-1:0];
      AW'(OFS_PRD_HI): rd_mux = prd_q[CW-1:DW];
      AW'(OFS_TCTL):   rd_mux[TMODE_LSB +: 2] = tmode_q;
      AW'(OFS_GCTL): begin
        rd_mux[1:0]            = grun_q;
        rd_mux[GMODE_LSB +: 2] = gmode_q;
      end
      AW'(OFS_WCTL): begin
        rd_mux[WFLAG_BIT] = flag_q;
        rd_mux[WEN_BIT]   = st_pre || st_run;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk #(
  parameter int CW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          pre,
  input logic          run,
  input logic          flag,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] prd,
  input logic          pulse
);
  AST_ARM_VIA_PRE: assert property (@(posedge clk) disable iff (rst)
    (run && !$past(run) && !$past(rst)) |-> $past(pre)); // R4

  AST_NO_DISARM: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !$past(rst)) |-> run); // R10

  AST_PRD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(rst)) |-> $stable(prd)); // R10

  AST_TMO_MARK: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> (flag && cnt == '0)); // R7

  AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> $past(run)); // R7
endmodule

bind kwdog_top kwdog_chk #(.CW(2 * DW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .pre   (st_pre),
  .run   (st_run),
  .flag  (flag_q),
  .cnt   (cnt_w),
  .prd   (prd_q),
  .pulse (wd_rst_o)
);

// File: tb/kwdog_top_test.sv
module kwdog_top_test;
  localparam int RST_LEN = 4;
  localparam logic [7:0] A_CLO = 8'h10, A_CHI = 8'h14, A_PLO = 8'h18, A_PHI = 8'h1C;
  localparam logic [7:0] A_TCTL = 8'h20, A_GCTL = 8'h24, A_WCTL = 8'h28;
  localparam logic [31:0] K1_EN = 32'hA5C6_4000, K2_EN = 32'hDA7E_4000;
  localparam logic [31:0] K1 = 32'hA5C6_0000, K2 = 32'hDA7E_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_rdata;
  logic        wd_rst_o;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  kwdog_top #(.RST_LEN(RST_LEN)) uut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .wd_rst_o(wd_rst_o)
  );

  function automatic logic [31:0] wctl_exp(input logic fl, input logic en);
    return {16'h0, fl, en, 14'h0};
  endfunction

  function automatic logic [31:0] gctl_val(input logic [1:0] mode, input logic hi, input logic lo);
    return {28'h0, mode, hi, lo};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic pulse_count(input int cyc, output int hi);
    hi = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (wd_rst_o) hi++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, plo, phi;
    int hi;
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // R1: reset state
    check("R1 rst_o", {31'h0, wd_rst_o}, 32'h0);
    for (int a = 8'h10; a <= 8'h28; a += 4) begin
      rd(8'(a), v);
      check("R1 reg zero", v, 32'h0);
    end

    // R2: readback of map and fields
    plo = $urandom(); phi = $urandom();
    wr(A_PLO, plo); wr(A_PHI, phi);
    wr(A_TCTL, 32'hFFFF_FF80); wr(A_GCTL, gctl_val(2'd2, 1'b1, 1'b1));
    rd(A_PLO, v);  check("R2 period lo", v, plo);
    rd(A_PHI, v);  check("R2 period hi", v, phi);
    rd(A_TCTL, v); check("R2 timer ctl", v, 32'h80);
    rd(A_GCTL, v); check("R2 global ctl", v, 32'hB);
    rd(8'h2C, v);  check("R2 unmapped", v, 32'h0);

    // R3: half held in reset
    wr(A_GCTL, gctl_val(2'd2, 1'b0, 1'b0));
    wr(A_CLO, 32'h1234); wr(A_CHI, 32'h55);
    rd(A_CLO, v); check("R3 lo held", v, 32'h0);
    rd(A_CHI, v); check("R3 hi held", v, 32'h0);
    wr(A_GCTL, gctl_val(2'd2, 1'b1, 1'b1));
    wr(A_CLO, 32'h1234);
    rd(A_CLO, v); check("R3 lo released", v, 32'h1234);

    // R4/R5: arming rules
    wr(A_GCTL, gctl_val(2'd1, 1'b1, 1'b1));
    wr(A_WCTL, K1_EN);
    rd(A_WCTL, v); check("R4 wrong mode no arm", v, wctl_exp(1'b0, 1'b0));
    wr(A_GCTL, gctl_val(2'd2, 1'b1, 1'b1));
    wr(A_WCTL, K1);
    rd(A_WCTL, v); check("R4 no enable no arm", v, wctl_exp(1'b0, 1'b0));
    wr(A_WCTL, K2_EN);
    rd(A_WCTL, v); check("R5 second key while off", v, wctl_exp(1'b0, 1'b0));
    wr(A_WCTL, K1_EN);
    rd(A_WCTL, v); check("R4 pre-armed", v, wctl_exp(1'b0, 1'b1));
    wr(A_WCTL, 32'h1111_4000);
    rd(A_WCTL, v); check("R5 wrong key back to off", v, wctl_exp(1'b0, 1'b0));

    // R6 carry setup, then arm
    wr(A_CLO, 32'hFFFF_FFFE); wr(A_CHI, 32'h0);
    wr(A_PLO, 32'h10); wr(A_PHI, 32'h1);
    wr(A_WCTL, K1_EN); wr(A_WCTL, K2_EN);
    rd(A_WCTL, v); check("R4 running", v, wctl_exp(1'b0, 1'b1));
    rd(A_CLO, v);  check("R4 arm keeps count", v, 32'hFFFF_FFFE);
    ticks(3);
    rd(A_CLO, v); check("R6 carry lo", v, 32'h1);
    rd(A_CHI, v); check("R6 carry hi", v, 32'h1);

    // R10: lock while running
    wr(A_GCTL, 32'h0); wr(A_TCTL, 32'h0); wr(A_PLO, 32'h3); wr(A_PHI, 32'h0);
    wr(A_CLO, 32'h55); wr(A_CHI, 32'h0); wr(A_WCTL, 32'h0);
    rd(A_GCTL, v); check("R10 global locked", v, 32'hB);
    rd(A_TCTL, v); check("R10 timer locked", v, 32'h80);
    rd(A_PLO, v);  check("R10 period locked", v, 32'h10);
    rd(A_CLO, v);  check("R10 counter locked", v, 32'h1);
    rd(A_WCTL, v); check("R10 no disarm", v, wctl_exp(1'b0, 1'b1));

    // R8: keep-alive without enable bit
    wr(A_WCTL, K1); wr(A_WCTL, K2);
    rd(A_CLO, v); check("R8 service lo", v, 32'h0);
    rd(A_CHI, v); check("R8 service hi", v, 32'h0);

    // R9: broken sequence
    ticks(2);
    wr(A_WCTL, K1); wr(A_WCTL, 32'h1234_0000); wr(A_WCTL, K2);
    rd(A_CLO, v); check("R9 broken sequence", v, 32'h2);
    wr(A_WCTL, K2);
    rd(A_CLO, v); check("R9 lone second key", v, 32'h2);

    // Phase B: short period
    do_reset();
    wr(A_GCTL, gctl_val(2'd2, 1'b1, 1'b1)); wr(A_TCTL, 32'h40); wr(A_PLO, 32'h5);
    wr(A_WCTL, K1_EN); wr(A_WCTL, K2_EN);

    // R6/R8 random
    for (int it = 0; it < 12; it++) begin
      int k;
      k = $urandom_range(0, 4);
      wr(A_WCTL, K1); wr(A_WCTL, K2);
      ticks(k);
      rd(A_CLO, v); check("R6 random count", v, 32'(k));
      check("R6 no pulse", {31'h0, wd_rst_o}, 32'h0);
    end

    // R7: timeout
    wr(A_WCTL, K1); wr(A_WCTL, K2);
    ticks(5);
    check("R7 no pulse yet", {31'h0, wd_rst_o}, 32'h0);
    pulse_count(RST_LEN + 2, hi);
    check("R7 pulse width", 32'(hi), 32'(RST_LEN));
    rd(A_WCTL, v); check("R7 flag set", v, wctl_exp(1'b1, 1'b1));
    rd(A_CLO, v);  check("R7 count cleared", v, 32'h0);

    // R11: flag clear, then clear colliding with timeout
    wr(A_WCTL, 32'h0000_8000);
    rd(A_WCTL, v); check("R11 flag cleared", v, wctl_exp(1'b0, 1'b1));
    ticks(5);
    pulse_count(RST_LEN + 2, hi);
    ticks(4);
    ticks(1); wr(A_WCTL, 32'h0000_8000);
    pulse_count(RST_LEN + 2, hi);
    check("R11 collision pulse", 32'(hi), 32'(RST_LEN - 1));
    rd(A_WCTL, v); check("R11 timeout wins", v, wctl_exp(1'b1, 1'b1));

    // R12: service colliding with match
    wr(A_WCTL, 32'h0000_8000);
    wr(A_WCTL, K1);
    ticks(4);
    ticks(1); wr(A_WCTL, K2);
    pulse_count(RST_LEN + 2, hi);
    check("R12 no pulse", 32'(hi), 32'h0);
    rd(A_WCTL, v); check("R12 no flag", v, wctl_exp(1'b0, 1'b1));
    rd(A_CLO, v);  check("R12 count cleared", v, 32'h0);

    summary();
    $finish;
  end
endmodule